// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Long Unit

This execution unit takes one 32-bit instruction word, two 32-bit source operands and a 64-bit accumulator supplied as a pair of 32-bit words. It forms two signed 16x16 products. The low halves of the operands make one product and the high halves make the other. The second operand may have its halves exchanged before multiplying. The unit then adds the two products, or subtracts the second from the first. It adds that signed value to the accumulator and returns the 64-bit result as a low word and a high word, together with the two destination indices that the result is to be written to.

The unit also decodes the register indices of the instruction for the register file around it, and tests the instruction's condition field against the supplied NZCV flags. An instruction whose condition fails completes without a write: the write enable is low and the result ports keep their previous contents. The unit has one register stage. A result appears the cycle after `in_valid` is high.

Top module: `hwmac_long`

## Requirements
- R1: While and after reset, `out_valid` and `out_wr_en` are 0, and `res_lo`, `res_hi`, `wb_lo_idx` and `wb_hi_idx` are 0.
- R2: When `in_valid` is 1, `out_valid` is 1 in the next cycle. When `in_valid` is 0, `out_valid` and `out_wr_en` are 0 in the next cycle.
- R3: The read indices come straight from the instruction: operand A from bits 3:0, operand B from bits 11:8, accumulator low from bits 15:12 and accumulator high from bits 19:16. On a write, `wb_lo_idx` and `wb_hi_idx` carry bits 15:12 and bits 19:16 with the result.
- R4: With instruction bit 6 = 0, the result is acc + sA(lo)*sB(lo) + sA(hi)*sB(hi), where the halves are taken as signed 16-bit values.
- R5: With instruction bit 6 = 1, the result is acc + sA(lo)*sB(lo) - sA(hi)*sB(hi).
- R6: With instruction bit 5 = 1, the two 16-bit halves of operand B are exchanged before both products are formed.
- R7: The accumulator is {acc_hi, acc_lo}, with acc_lo taken unsigned as the low 32 bits. Accumulation wraps modulo 2^64, with no saturation.
- R8: The products are combined at 33 bits or more and sign-extended, so that two products of -32768*-32768 add exactly to +2^31.
- R9: A condition field (bits 31:28) of 0xE always writes. A field of 0xF never writes.
- R10: Other condition codes test flags = {N,Z,C,V} (bit 3 = N, bit 0 = V): 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R11: When the condition fails, `out_valid` is 1, `out_wr_en` is 0, and `res_lo`, `res_hi`, `wb_lo_idx` and `wb_hi_idx` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| src_a | input | 32 | First multiplicand |
| src_b | input | 32 | Second multiplicand |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word |
| rd_a_idx | output | 4 | Read index of operand A |
| rd_b_idx | output | 4 | Read index of operand B |
| rd_lo_idx | output | 4 | Read index of accumulator low word |
| rd_hi_idx | output | 4 | Read index of accumulator high word |
| out_valid | output | 1 | Instruction completed last cycle |
| out_wr_en | output | 1 | Result is to be written |
| wb_lo_idx | output | 4 | Destination index of low word |
| wb_hi_idx | output | 4 | Destination index of high word |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |

## Verification
The swap of operand B and the subtract mode act on the same products in the same cycle. The bench issues instructions with both bits 5 and 6 set, using halves chosen so that a missing swap, or an add in place of the subtract, changes the result. The failing-condition path and a back-to-back issue also meet in one cycle: a failing instruction follows a passing one directly. The check confirms that the output stays valid, that the write enable drops, and that the earlier result and indices are still on the ports.

// File: rtl/hwmac_pkg.sv
package hwmac_pkg;
    localparam int IDX_W   = 4;
    localparam int COND_W  = 4;
    localparam int FLAG_W  = 4;
    localparam int INSTR_W = 32;

    // field positions the decode depends on
    localparam int A_IDX_LSB  = 0;
    localparam int B_IDX_LSB  = 8;
    localparam int LO_IDX_LSB = 12;
    localparam int HI_IDX_LSB = 16;
    localparam int COND_LSB   = 28;
    localparam int SWAP_BIT   = 5;
    localparam int SUB_BIT    = 6;

    // flag bit positions
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cond_e;

    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic [IDX_W-1:0]  hi_idx;
        logic [IDX_W-1:0]  lo_idx;
        logic [IDX_W-1:0]  b_idx;
        logic [IDX_W-1:0]  a_idx;
        logic              sub;
        logic              swap;
    } op_fields_t;

    function automatic op_fields_t decode_op(input logic [INSTR_W-1:0] w);
        op_fields_t f;
        f.cond   = w[COND_LSB   +: COND_W];
        f.hi_idx = w[HI_IDX_LSB +: IDX_W];
        f.lo_idx = w[LO_IDX_LSB +: IDX_W];
        f.b_idx  = w[B_IDX_LSB  +: IDX_W];
        f.a_idx  = w[A_IDX_LSB  +: IDX_W];
        f.sub    = w[SUB_BIT];
        f.swap   = w[SWAP_BIT];
        return f;
    endfunction
endpackage

// File: rtl/hwmac_cond.sv
module hwmac_cond
    import hwmac_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass
);
    logic n, z, c, v;

    always_comb begin
        n = flags[FLG_N];
        z = flags[FLG_Z];
        c = flags[FLG_C];
        v = flags[FLG_V];
        unique case (cond_e'(cond))
            CC_EQ:   pass = z;
            CC_NE:   pass = !z;
            CC_CS:   pass = c;
            CC_CC:   pass = !c;
            CC_MI:   pass = n;
            CC_PL:   pass = !n;
            CC_VS:   pass = v;
            CC_VC:   pass = !v;
            CC_HI:   pass = c && !z;
            CC_LS:   pass = !c || z;
            CC_GE:   pass = (n == v);
            CC_LT:   pass = (n != v);
            CC_GT:   pass = !z && (n == v);
            CC_LE:   pass = z || (n != v);
            CC_AL:   pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/hwmac_dual_prod.sv
module hwmac_dual_prod #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]     op_a,
    input  logic [DATA_W-1:0]     op_b,
    input  logic                  swap,
    input  logic                  sub,
    output logic signed [DATA_W:0] combined
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = 2;
    localparam int COMB_W = DATA_W + 1;
    localparam logic signed [COMB_W-1:0] MAX_MAG = COMB_W'(1) <<< (DATA_W - 1);

    logic [DATA_W-1:0]        b_eff;
    logic signed [DATA_W-1:0] prod [LANES];
    logic signed [COMB_W-1:0] prod_x [LANES];

    always_comb begin
        b_eff = swap ? {op_b[HALF_W-1:0], op_b[DATA_W-1:HALF_W]} : op_b;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [HALF_W-1:0] ha, hb;
        assign ha        = op_a[l*HALF_W +: HALF_W];
        assign hb        = b_eff[l*HALF_W +: HALF_W];
        assign prod[l]   = ha * hb;
        assign prod_x[l] = {prod[l][DATA_W-1], prod[l]};
    end

    always_comb begin
        combined = sub ? (prod_x[0] - prod_x[1]) : (prod_x[0] + prod_x[1]);
    end

    always_comb begin
        AST_COMBINE_RANGE: assert ((combined <= MAX_MAG) && (combined >= -MAX_MAG)) // R8
            else $error("combined product out of range");
    end
endmodule

// File: rtl/hwmac_long.sv
module hwmac_long
    import hwmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [FLAG_W-1:0]  flags,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [DATA_W-1:0]  acc_lo,
    input  logic [DATA_W-1:0]  acc_hi,
    output logic [IDX_W-1:0]   rd_a_idx,
    output logic [IDX_W-1:0]   rd_b_idx,
    output logic [IDX_W-1:0]   rd_lo_idx,
    output logic [IDX_W-1:0]   rd_hi_idx,
    output logic               out_valid,
    output logic               out_wr_en,
    output logic [IDX_W-1:0]   wb_lo_idx,
    output logic [IDX_W-1:0]   wb_hi_idx,
    output logic [DATA_W-1:0]  res_lo,
    output logic [DATA_W-1:0]  res_hi
);
    localparam int ACC_W  = 2 * DATA_W;
    localparam int COMB_W = DATA_W + 1;

    typedef struct packed {
        logic              valid;
        logic              wr_en;
        logic [IDX_W-1:0]  lo_idx;
        logic [IDX_W-1:0]  hi_idx;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } stage_t;

    op_fields_t               fld;
    logic                     cond_ok;
    logic signed [COMB_W-1:0] combined;
    logic [ACC_W-1:0]         acc_full;
    logic [ACC_W-1:0]         sum_full;
    stage_t                   st_d, st_q;

    always_comb fld = decode_op(instr);

    hwmac_cond u_cond (
        .cond  (fld.cond),
        .flags (flags),
        .pass  (cond_ok)
    );

    hwmac_dual_prod #(.DATA_W(DATA_W)) u_prod (
        .op_a     (src_a),
        .op_b     (src_b),
        .swap     (fld.swap),
        .sub      (fld.sub),
        .combined (combined)
    );

    always_comb begin
        acc_full = {acc_hi, acc_lo};
        sum_full = acc_full + {{(ACC_W-COMB_W){combined[COMB_W-1]}}, combined};
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.wr_en = in_valid && cond_ok;
        if (in_valid && cond_ok) begin
            st_d.lo     = sum_full[DATA_W-1:0];
            st_d.hi     = sum_full[ACC_W-1:DATA_W];
            st_d.lo_idx = fld.lo_idx;
            st_d.hi_idx = fld.hi_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_a_idx  = fld.a_idx;
    assign rd_b_idx  = fld.b_idx;
    assign rd_lo_idx = fld.lo_idx;
    assign rd_hi_idx = fld.hi_idx;
    assign out_valid = st_q.valid;
    assign out_wr_en = st_q.wr_en;
    assign wb_lo_idx = st_q.lo_idx;
    assign wb_hi_idx = st_q.hi_idx;
    assign res_lo    = st_q.lo;
    assign res_hi    = st_q.hi;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_en)); // R2
    AST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[COND_LSB +: COND_W] == CC_AL) |=> out_wr_en); // R9
    AST_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[COND_LSB +: COND_W] == CC_NV) |=> !out_wr_en); // R9
    AST_HOLD_ON_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr_en |-> ($stable(res_lo) && $stable(res_hi)
                        && $stable(wb_lo_idx) && $stable(wb_hi_idx))); // R11
endmodule

// File: tb/hwmac_long_test.sv
module hwmac_long_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic [3:0]  cond;
        logic        sub;
        logic        swap;
        logic [3:0]  flg;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] hi;
        logic [31:0] lo;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{4'hE, 1'b0, 1'b0, 4'h0, 32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 32'h0000_000A},
        '{4'hE, 1'b1, 1'b0, 4'h0, 32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 32'h0000_000A},
        '{4'hE, 1'b0, 1'b1, 4'h0, 32'hFFFD_7FFF, 32'h8000_0011, 32'h1234_5678, 32'h9ABC_DEF0},
        '{4'hE, 1'b1, 1'b1, 4'h0, 32'h0007_0002, 32'h0003_0100, 32'h0000_0000, 32'h0000_1000},
        '{4'h0, 1'b0, 1'b0, 4'h4, 32'h8000_8000, 32'h7FFF_7FFF, 32'hFFFF_FFFF, 32'h0000_0000},
        '{4'hA, 1'b1, 1'b0, 4'h9, 32'hABCD_1234, 32'h5678_EF01, 32'h0000_0001, 32'hFFFF_FFFF},
        '{4'hC, 1'b0, 1'b0, 4'h0, 32'h1111_2222, 32'h3333_4444, 32'h8000_0000, 32'h0000_0000},
        '{4'h8, 1'b1, 1'b1, 4'h2, 32'hFFFF_FFFF, 32'hFFFF_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  flags = '0;
    logic [31:0] src_a = '0, src_b = '0, acc_lo = '0, acc_hi = '0;
    logic [3:0]  rd_a_idx, rd_b_idx, rd_lo_idx, rd_hi_idx, wb_lo_idx, wb_hi_idx;
    logic        out_valid, out_wr_en;
    logic [31:0] res_lo, res_hi;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_lo = '0, exp_hi = '0;
    logic [3:0]  exp_li = '0, exp_hi_i = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwmac_long uut (.*);

    function automatic logic [31:0] mk(input logic [3:0] c, input logic sub, input logic sw,
                                       input logic [3:0] hi, lo, b, a);
        return {c, 8'h00, hi, lo, b, 1'b0, sub, sw, 1'b1, a};
    endfunction

    function automatic logic cond_ref(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cf, v;
        {n, z, cf, v} = f;
        case (c)
            4'h0: return z;        4'h1: return !z;
            4'h2: return cf;       4'h3: return !cf;
            4'h4: return n;        4'h5: return !n;
            4'h6: return v;        4'h7: return !v;
            4'h8: return cf && !z; 4'h9: return !cf || z;
            4'hA: return n == v;   4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] mac_ref(input logic sub, input logic sw,
                                            input logic [31:0] a, b, hi, lo);
        logic [31:0] bb;
        longint p0, p1, acc;
        bb  = sw ? {b[15:0], b[31:16]} : b;
        p0  = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]));
        p1  = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
        acc = longint'({hi, lo});
        return 64'(sub ? (acc + p0 - p1) : (acc + p0 + p1));
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one op; results sampled at the following falling edge
    task automatic issue(input logic [3:0] c, input logic sub, input logic sw, input logic [3:0] f,
                         input logic [31:0] a, b, hi, lo, input logic [3:0] hidx, lidx, string req);
        logic pass;
        logic [63:0] r;
        @(negedge clk);
        instr = mk(c, sub, sw, hidx, lidx, 4'h7, 4'h3);
        flags = f; src_a = a; src_b = b; acc_hi = hi; acc_lo = lo; in_valid = 1'b1;
        pass = cond_ref(c, f);
        if (pass) begin
            r = mac_ref(sub, sw, a, b, hi, lo);
            exp_lo = r[31:0]; exp_hi = r[63:32]; exp_li = lidx; exp_hi_i = hidx;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {req, " R2 valid"}, 64'(out_valid), 64'd1);
        chk(out_wr_en == pass, {req, " wr_en"}, 64'(out_wr_en), 64'(pass));
        chk({res_hi, res_lo} == {exp_hi, exp_lo}, {req, " result"}, {res_hi, res_lo}, {exp_hi, exp_lo});
        chk({wb_hi_idx, wb_lo_idx} == {exp_hi_i, exp_li}, {req, " R3 wb idx"},
            64'({wb_hi_idx, wb_lo_idx}), 64'({exp_hi_i, exp_li}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({out_valid, out_wr_en, res_hi, res_lo, wb_hi_idx, wb_lo_idx} == '0, "R1 in reset",
            {res_hi, res_lo}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk({out_valid, out_wr_en, res_hi, res_lo} == '0, "R1 after reset", {res_hi, res_lo}, 64'd0);

        // R3 read index decode
        instr = mk(4'hE, 1'b0, 1'b0, 4'h9, 4'h5, 4'hC, 4'h1);
        #1;
        chk({rd_hi_idx, rd_lo_idx, rd_b_idx, rd_a_idx} == 16'h95C1, "R3 read idx",
            64'({rd_hi_idx, rd_lo_idx, rd_b_idx, rd_a_idx}), 64'h95C1);

        // table walk (R4 R5 R6 R7 R10 R11)
        for (int i = 0; i < NV; i++)
            issue(TBL[i].cond, TBL[i].sub, TBL[i].swap, TBL[i].flg, TBL[i].a, TBL[i].b,
                  TBL[i].hi, TBL[i].lo, 4'(i + 2), 4'(i + 1), $sformatf("R4/R5/R6 vec%0d", i));

        // R4 add: 10 + 2*4 + 3*5 = 33
        issue(4'hE, 1'b0, 1'b0, 4'h0, 32'h0003_0002, 32'h0005_0004, 32'h0, 32'hA, 4'h2, 4'h1, "R4 add");
        chk(res_lo == 32'd33, "R4 add value", 64'(res_lo), 64'd33);
        // R5 subtract: 10 + 8 - 15 = 3
        issue(4'hE, 1'b1, 1'b0, 4'h0, 32'h0003_0002, 32'h0005_0004, 32'h0, 32'hA, 4'h2, 4'h1, "R5 sub");
        chk(res_lo == 32'd3, "R5 sub value", 64'(res_lo), 64'd3);
        // R6 swap with subtract: 10 + 2*5 - 3*4 = 8
        issue(4'hE, 1'b1, 1'b1, 4'h0, 32'h0003_0002, 32'h0005_0004, 32'h0, 32'hA, 4'h2, 4'h1, "R6 swap");
        chk(res_lo == 32'd8, "R6 swap value", 64'(res_lo), 64'd8);
        // R8 two -32768*-32768 products -> +2^31
        issue(4'hE, 1'b0, 1'b0, 4'h0, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0, 4'h4, 4'h3, "R8 extreme");
        chk({res_hi, res_lo} == 64'h0000_0000_8000_0000, "R8 value", {res_hi, res_lo}, 64'h8000_0000);
        // R7 low word unsigned
        issue(4'hE, 1'b0, 1'b0, 4'h0, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 4'h4, 4'h3, "R7 zext");
        chk({res_hi, res_lo} == 64'h0000_0000_8000_0000, "R7 zext value", {res_hi, res_lo}, 64'h8000_0000);
        // R7 wrap modulo 2^64: all-ones + 1 = 0
        issue(4'hE, 1'b0, 1'b0, 4'h0, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h6, 4'h5, "R7 wrap");
        chk({res_hi, res_lo} == 64'h0, "R7 wrap value", {res_hi, res_lo}, 64'h0);
        // R11 fail right after pass: hold
        issue(4'hE, 1'b0, 1'b0, 4'h0, 32'h0002_0002, 32'h0003_0003, 32'h0, 32'h0, 4'h8, 4'h7, "R11 prior");
        issue(4'h0, 1'b0, 1'b0, 4'h0, 32'h1234_5678, 32'h1, 32'h5, 32'h5, 4'hF, 4'hE, "R11 skipped");
        chk({res_hi, res_lo} == 64'd12 && wb_lo_idx == 4'h7, "R11 hold value", {res_hi, res_lo}, 64'd12);
        // R9 never-code with every flag set
        issue(4'hF, 1'b0, 1'b0, 4'hF, 32'h1, 32'h1, 32'h0, 32'h0, 4'h1, 4'h1, "R9 never");
        issue(4'hE, 1'b1, 1'b0, 4'h0, 32'h1, 32'h1, 32'h0, 32'h0, 4'h1, 4'h2, "R9 always");
        // R10 all codes against all flag patterns
        for (int c = 0; c < 14; c++)
            for (int f = 0; f < 16; f++)
                issue(4'(c), 1'(f[0]), 1'(c[0]), 4'(f), 32'(c * 977 + f), 32'(f * 31 + 5),
                      32'(c), 32'(f), 4'(c), 4'(f), $sformatf("R10 code%0d flags%0d", c, f));
        // R2 idle cycle
        @(negedge clk);
        chk(out_valid == 1'b0 && out_wr_en == 1'b0, "R2 idle", 64'({out_valid, out_wr_en}), 64'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule